// File: doc/BRIEF.md
# Banked Address Window Mapper

This block turns a 16-bit processor address into a memory-chip select and a byte offset inside that chip. The processor space is cut into 32 slots of 2 KB. Each slot holds a chip number, a page number, a mapped flag and a RAM flag. A separate table of eight 1 KB slots does the same for the 8 KB video pattern space. Software-style commands fill these tables. A command names a window size, a base address, a chip and a bank number. The block writes the matching run of slots in one clock edge.

The bank is reduced to the size of the chosen chip. If the chip is smaller than the window, the window is filled with consecutive chip pages that wrap around. Chip sizes, presence and RAM capability come in as configuration inputs, one set per chip. Translation is combinational. It yields the chip, the offset, a gated write enable and an open-bus flag for slots with nothing behind them.

Top module: `bank_window_mapper`

## Requirements
- R1: For a processor address, slot = address bits [15:11]. `cpu_chip_o` is that slot's chip. `cpu_off_o` = page * 2048 + address bits [10:0].
- R2: On a processor command, `cmd_size_i` codes 0,1,2,3,4 select windows of 2,4,8,16,32 KB. Codes 5 to 7 act as code 4. A window of 2^k slots starts at the command slot rounded down to a multiple of 2^k, and every slot in it is rewritten.
- R3: If the chip is at least as large as the window, the bank is ANDed with (chip size / window size) - 1. Slot x of the window (x counted from 0) then gets page bank * 2^k + x.
- R4: If the chip is smaller than the window, slot x gets page (bank * 2^k + x) AND (chip size / 2 KB - 1).
- R5: `cpu_we_o` is high only when `cpu_wr_i` is high and the addressed slot is mapped to a chip flagged in `chip_ram_i`.
- R6: `cpu_open_bus_o` is high for an unmapped slot. A processor command that names a chip whose `chip_present_i` bit is low unmaps every slot of its window and clears their RAM flags.
- R7: On a video command (`cmd_video_i` = 1), codes 0 to 3 select windows of 1, 2, 4 or 8 KB, and codes above 3 act as 3. The same masking and wrap rules apply, using 1 KB pages. Video slot = `vid_addr_i[12:10]`. `vid_off_o` = page * 1024 + `vid_addr_i[9:0]`. `vid_ram_o` copies the chip's RAM flag, and `vid_valid_o` goes high.
- R8: A video command that names a chip that is not present leaves every video slot unchanged.
- R9: After reset, every processor slot is unmapped with its RAM flag clear. Every video slot has chip 0, page 0, valid 0 and RAM 0.
- R10: A command takes effect on the clock edge where `cmd_valid_i` is high, and the new mapping is seen from the next cycle on. `chip_log2_i` holds log2 of each chip's byte size, from 11 to 20, LOG_W bits per chip with chip 0 in the lowest bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chip_log2_i | input | NUM_CHIPS*LOG_W | log2 of each chip's byte size |
| chip_present_i | input | NUM_CHIPS | Chip is fitted |
| chip_ram_i | input | NUM_CHIPS | Chip is writable |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_video_i | input | 1 | 0: processor table, 1: video table |
| cmd_size_i | input | 3 | Window size code |
| cmd_chip_i | input | log2(NUM_CHIPS) | Chip to map |
| cmd_addr_i | input | CPU_AW | Address inside the target window |
| cmd_bank_i | input | BANK_W | Bank number |
| cpu_addr_i | input | CPU_AW | Processor address to translate |
| cpu_wr_i | input | 1 | Processor write request |
| cpu_chip_o | output | log2(NUM_CHIPS) | Selected chip |
| cpu_off_o | output | OFF_W | Byte offset inside the chip |
| cpu_we_o | output | 1 | Gated write enable |
| cpu_open_bus_o | output | 1 | Slot unmapped, bus keeps last value |
| vid_addr_i | input | VID_AW | Pattern-space address |
| vid_chip_o | output | log2(NUM_CHIPS) | Selected chip |
| vid_off_o | output | OFF_W | Byte offset inside the chip |
| vid_ram_o | output | 1 | Slot maps a writable chip |
| vid_valid_o | output | 1 | Slot has been assigned |

## Verification
The translation outputs are due in the same cycle as the address. A table change is due one cycle after the edge that samples `cmd_valid_i`. The bench drives every input on the falling edge and never puts a command and a lookup in the same cycle. The monitor compares one queued lookup 1 ns after each rising edge. By then the slot tables have settled from any earlier command, and the address has been stable for half a period.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int CPU_PAGE_LOG = 11;
  localparam int VID_PAGE_LOG = 10;
  localparam int CPU_MAX_CODE = 4;
  localparam int VID_MAX_CODE = 3;

  typedef enum logic {
    SPACE_CPU = 1'b0,
    SPACE_VID = 1'b1
  } space_e;
endpackage

// File: rtl/bwm_slot_table.sv
module bwm_slot_table #(
  parameter int SLOTS        = 32,
  parameter int SLOT_LOG     = 11,
  parameter int MAX_CODE     = 4,
  parameter int NUM_CHIPS    = 4,
  parameter int LOG_W        = 5,
  parameter int BANK_W       = 8,
  parameter int OFF_W        = 20,
  parameter bit UNMAP_ABSENT = 1'b1,
  localparam int SIDX_W = $clog2(SLOTS),
  localparam int AW     = SLOT_LOG + SIDX_W,
  localparam int CHIP_W = $clog2(NUM_CHIPS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CHIPS*LOG_W-1:0] chip_log2_i,
  input  logic [NUM_CHIPS-1:0]       chip_present_i,
  input  logic [NUM_CHIPS-1:0]       chip_ram_i,
  input  logic                       upd_i,
  input  logic [2:0]                 upd_size_i,
  input  logic [AW-1:0]              upd_addr_i,
  input  logic [CHIP_W-1:0]          upd_chip_i,
  input  logic [BANK_W-1:0]          upd_bank_i,
  input  logic [AW-1:0]              look_addr_i,
  output logic                       look_mapped_o,
  output logic                       look_ram_o,
  output logic [CHIP_W-1:0]          look_chip_o,
  output logic [OFF_W-1:0]           look_off_o
);
  localparam int PG_W   = OFF_W - SLOT_LOG;
  localparam int WIDE_A = BANK_W + MAX_CODE + 1;
  localparam int WIDE_W = (WIDE_A > PG_W) ? ((WIDE_A > SIDX_W) ? WIDE_A : SIDX_W)
                                          : ((PG_W > SIDX_W) ? PG_W : SIDX_W);

  logic [2:0]        code;
  logic [LOG_W-1:0]  sel_log;
  logic              sel_present, sel_ram;
  logic [PG_W:0]     pg_one;
  logic [PG_W-1:0]   pg_mask;
  logic [SIDX_W-1:0] upd_slot, span_mask, look_slot;

  logic [SLOTS-1:0]  mapped_v, ram_v;
  logic [CHIP_W-1:0] chip_v [SLOTS];
  logic [PG_W-1:0]   page_v [SLOTS];

  assign code        = (upd_size_i > 3'(MAX_CODE)) ? 3'(MAX_CODE) : upd_size_i;
  assign sel_log     = chip_log2_i[upd_chip_i*LOG_W +: LOG_W];
  assign sel_present = chip_present_i[upd_chip_i];
  assign sel_ram     = chip_ram_i[upd_chip_i];
  // page mask = chip pages - 1; a full-width chip wraps to all ones
  assign pg_one      = (PG_W+1)'(1) << (sel_log - LOG_W'(SLOT_LOG));
  assign pg_mask     = pg_one[PG_W-1:0] - PG_W'(1);
  assign upd_slot    = upd_addr_i[SLOT_LOG +: SIDX_W];
  assign span_mask   = (SIDX_W'(1) << code) - SIDX_W'(1);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic              in_win;
    logic [SIDX_W-1:0] idx;
    logic [WIDE_W-1:0] wide;
    logic [PG_W-1:0]   page_n;
    logic              mapped_q, ram_q;
    logic [CHIP_W-1:0] chip_q;
    logic [PG_W-1:0]   page_q;

    assign idx    = SIDX_W'(s) & span_mask;
    assign in_win = (SIDX_W'(s) & ~span_mask) == (upd_slot & ~span_mask);
    // one formula serves both the masked-bank and the wrap-fill case
    assign wide   = (WIDE_W'(upd_bank_i) << code) | WIDE_W'(idx);
    assign page_n = wide[PG_W-1:0] & pg_mask;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mapped_q <= 1'b0;
        ram_q    <= 1'b0;
        chip_q   <= '0;
        page_q   <= '0;
      end else if (upd_i && in_win) begin
        if (sel_present) begin
          mapped_q <= 1'b1;
          ram_q    <= sel_ram;
          chip_q   <= upd_chip_i;
          page_q   <= page_n;
        end else if (UNMAP_ABSENT) begin
          mapped_q <= 1'b0;
          ram_q    <= 1'b0;
          chip_q   <= '0;
          page_q   <= '0;
        end
      end
    end

    assign mapped_v[s] = mapped_q;
    assign ram_v[s]    = ram_q;
    assign chip_v[s]   = chip_q;
    assign page_v[s]   = page_q;
  end

  assign look_slot     = look_addr_i[SLOT_LOG +: SIDX_W];
  assign look_mapped_o = mapped_v[look_slot];
  assign look_ram_o    = ram_v[look_slot];
  assign look_chip_o   = chip_v[look_slot];
  assign look_off_o    = {page_v[look_slot], look_addr_i[SLOT_LOG-1:0]};

  p_win_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && sel_present) |=> (mapped_v[$past(upd_slot)] && (ram_v[$past(upd_slot)] == $past(sel_ram))));

  if (UNMAP_ABSENT) begin : g_chk_unmap
    p_absent_unmap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i && !sel_present) |=> (!mapped_v[$past(upd_slot)] && !ram_v[$past(upd_slot)]));
  end else begin : g_chk_keep
    p_absent_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i && !sel_present) |=> ($stable(mapped_v) && $stable(ram_v)));
  end
endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
  import bwm_pkg::*;
#(
  parameter int NUM_CHIPS = 4,
  parameter int LOG_W     = 5,
  parameter int BANK_W    = 8,
  parameter int OFF_W     = 20,
  parameter int CPU_AW    = 16,
  parameter int VID_AW    = 13,
  localparam int CHIP_W   = $clog2(NUM_CHIPS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CHIPS*LOG_W-1:0] chip_log2_i,
  input  logic [NUM_CHIPS-1:0]       chip_present_i,
  input  logic [NUM_CHIPS-1:0]       chip_ram_i,
  input  logic                       cmd_valid_i,
  input  logic                       cmd_video_i,
  input  logic [2:0]                 cmd_size_i,
  input  logic [CHIP_W-1:0]          cmd_chip_i,
  input  logic [CPU_AW-1:0]          cmd_addr_i,
  input  logic [BANK_W-1:0]          cmd_bank_i,
  input  logic [CPU_AW-1:0]          cpu_addr_i,
  input  logic                       cpu_wr_i,
  output logic [CHIP_W-1:0]          cpu_chip_o,
  output logic [OFF_W-1:0]           cpu_off_o,
  output logic                       cpu_we_o,
  output logic                       cpu_open_bus_o,
  input  logic [VID_AW-1:0]          vid_addr_i,
  output logic [CHIP_W-1:0]          vid_chip_o,
  output logic [OFF_W-1:0]           vid_off_o,
  output logic                       vid_ram_o,
  output logic                       vid_valid_o
);
  localparam int CPU_SLOTS = 1 << (CPU_AW - CPU_PAGE_LOG);
  localparam int VID_SLOTS = 1 << (VID_AW - VID_PAGE_LOG);

  space_e space;
  logic   cpu_upd, vid_upd, cpu_mapped, cpu_ram;

  assign space   = space_e'(cmd_video_i);
  assign cpu_upd = cmd_valid_i && (space == SPACE_CPU);
  assign vid_upd = cmd_valid_i && (space == SPACE_VID);

  bwm_slot_table #(
    .SLOTS(CPU_SLOTS), .SLOT_LOG(CPU_PAGE_LOG), .MAX_CODE(CPU_MAX_CODE),
    .NUM_CHIPS(NUM_CHIPS), .LOG_W(LOG_W), .BANK_W(BANK_W), .OFF_W(OFF_W),
    .UNMAP_ABSENT(1'b1)
  ) u_cpu_tbl (
    .clk_i, .rst_ni, .chip_log2_i, .chip_present_i, .chip_ram_i,
    .upd_i(cpu_upd), .upd_size_i(cmd_size_i), .upd_addr_i(cmd_addr_i),
    .upd_chip_i(cmd_chip_i), .upd_bank_i(cmd_bank_i),
    .look_addr_i(cpu_addr_i), .look_mapped_o(cpu_mapped), .look_ram_o(cpu_ram),
    .look_chip_o(cpu_chip_o), .look_off_o(cpu_off_o)
  );

  bwm_slot_table #(
    .SLOTS(VID_SLOTS), .SLOT_LOG(VID_PAGE_LOG), .MAX_CODE(VID_MAX_CODE),
    .NUM_CHIPS(NUM_CHIPS), .LOG_W(LOG_W), .BANK_W(BANK_W), .OFF_W(OFF_W),
    .UNMAP_ABSENT(1'b0)
  ) u_vid_tbl (
    .clk_i, .rst_ni, .chip_log2_i, .chip_present_i, .chip_ram_i,
    .upd_i(vid_upd), .upd_size_i(cmd_size_i), .upd_addr_i(cmd_addr_i[VID_AW-1:0]),
    .upd_chip_i(cmd_chip_i), .upd_bank_i(cmd_bank_i),
    .look_addr_i(vid_addr_i), .look_mapped_o(vid_valid_o), .look_ram_o(vid_ram_o),
    .look_chip_o(vid_chip_o), .look_off_o(vid_off_o)
  );

  assign cpu_open_bus_o = !cpu_mapped;
  assign cpu_we_o       = cpu_wr_i && cpu_mapped && cpu_ram;

  p_we_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_o |-> (cpu_wr_i && !cpu_open_bus_o));
endmodule

// File: tb/bank_window_mapper_tb_top.sv
module bank_window_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] chip_log2;
  logic [3:0]  chip_present, chip_ram;
  logic        cmd_valid = 1'b0, cmd_video = 1'b0;
  logic [2:0]  cmd_size = '0;
  logic [1:0]  cmd_chip = '0;
  logic [15:0] cmd_addr = '0;
  logic [7:0]  cmd_bank = '0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [1:0]  cpu_chip, vid_chip;
  logic [19:0] cpu_off, vid_off;
  logic        cpu_we, cpu_open, vid_ram, vid_valid;
  logic [12:0] vid_addr = '0;

  always #2 clk = ~clk;

  bank_window_mapper dut_i (
    .clk_i(clk), .rst_ni(rst_n), .chip_log2_i(chip_log2), .chip_present_i(chip_present),
    .chip_ram_i(chip_ram), .cmd_valid_i(cmd_valid), .cmd_video_i(cmd_video),
    .cmd_size_i(cmd_size), .cmd_chip_i(cmd_chip), .cmd_addr_i(cmd_addr), .cmd_bank_i(cmd_bank),
    .cpu_addr_i(cpu_addr), .cpu_wr_i(cpu_wr), .cpu_chip_o(cpu_chip), .cpu_off_o(cpu_off),
    .cpu_we_o(cpu_we), .cpu_open_bus_o(cpu_open), .vid_addr_i(vid_addr),
    .vid_chip_o(vid_chip), .vid_off_o(vid_off), .vid_ram_o(vid_ram), .vid_valid_o(vid_valid)
  );

  int logs [4] = '{17, 13, 11, 11};
  bit pres [4] = '{1, 1, 1, 0};
  bit rams [4] = '{0, 1, 1, 0};

  // reference tables
  bit m_map [32]; bit m_ram [32]; int m_chip [32]; int m_page [32];
  bit v_val [8];  bit v_ram [8];  int v_chip [8];  int v_page [8];

  typedef struct packed {
    logic        vid;
    logic [15:0] addr;
    logic        wr;
    logic [1:0]  chip;
    logic [19:0] off;
    logic        we;
    logic        open;
    logic        ram;
    logic        valid;
  } item_t;
  item_t exp_q [$];
  string tag_q [$];

  int checks = 0, failures = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_cpu(int k, int addr, int chip, int bank);
    int n = 1 << k;
    int start = (addr >> 11) & ~(n - 1) & 31;
    int pg = logs[chip] - 11;
    for (int x = 0; x < n; x++) begin
      if (!pres[chip]) begin
        m_map[start+x] = 0; m_ram[start+x] = 0; m_chip[start+x] = 0; m_page[start+x] = 0;
      end else begin
        m_map[start+x] = 1; m_ram[start+x] = rams[chip]; m_chip[start+x] = chip;
        if (pg >= k) m_page[start+x] = (bank & ((1 << (pg - k)) - 1)) * n + x;
        else         m_page[start+x] = (bank * n + x) & ((1 << pg) - 1);
      end
    end
  endtask

  task automatic model_vid(int k, int addr, int chip, int bank);
    int n = 1 << k;
    int start = (addr >> 10) & ~(n - 1) & 7;
    int pg = logs[chip] - 10;
    if (!pres[chip]) return;
    for (int x = 0; x < n; x++) begin
      v_val[start+x] = 1; v_ram[start+x] = rams[chip]; v_chip[start+x] = chip;
      if (pg >= k) v_page[start+x] = (bank & ((1 << (pg - k)) - 1)) * n + x;
      else         v_page[start+x] = (bank * n + x) & ((1 << pg) - 1);
    end
  endtask

  task automatic command(bit video, int size, int addr, int chip, int bank);
    int k;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_video = video; cmd_size = 3'(size);
    cmd_addr = 16'(addr); cmd_chip = 2'(chip); cmd_bank = 8'(bank);
    if (video) begin k = (size > 3) ? 3 : size; model_vid(k, addr, chip, bank); end
    else       begin k = (size > 4) ? 4 : size; model_cpu(k, addr, chip, bank); end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic probe_cpu(int addr, bit wr, string tag);
    item_t it;
    int s = (addr >> 11) & 31;
    @(negedge clk);
    cpu_addr = 16'(addr); cpu_wr = wr;
    it = '0;
    it.vid = 1'b0; it.addr = 16'(addr); it.wr = wr;
    it.chip = 2'(m_chip[s]);
    it.off = 20'(m_page[s] * 2048 + (addr & 2047));
    it.we = wr && m_map[s] && m_ram[s];
    it.open = !m_map[s];
    exp_q.push_back(it); tag_q.push_back(tag);
  endtask

  task automatic probe_vid(int addr, string tag);
    item_t it;
    int s = (addr >> 10) & 7;
    @(negedge clk);
    vid_addr = 13'(addr);
    it = '0;
    it.vid = 1'b1; it.addr = 16'(addr);
    it.chip = 2'(v_chip[s]);
    it.off = 20'(v_page[s] * 1024 + (addr & 1023));
    it.ram = v_ram[s]; it.valid = v_val[s];
    exp_q.push_back(it); tag_q.push_back(tag);
  endtask

  // monitor: one item per cycle, 1 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        item_t it;
        string tg;
        it = exp_q.pop_front();
        tg = tag_q.pop_front();
        if (!it.vid) begin
          chk(tg, "cpu_open_bus", int'(cpu_open), int'(it.open));
          chk(tg, "cpu_we", int'(cpu_we), int'(it.we));
          if (!it.open) begin
            chk(tg, "cpu_chip", int'(cpu_chip), int'(it.chip));
            chk(tg, "cpu_off", int'(cpu_off), int'(it.off));
          end
        end else begin
          chk(tg, "vid_valid", int'(vid_valid), int'(it.valid));
          chk(tg, "vid_ram", int'(vid_ram), int'(it.ram));
          chk(tg, "vid_chip", int'(vid_chip), int'(it.chip));
          chk(tg, "vid_off", int'(vid_off), int'(it.off));
        end
      end
    end
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      chip_log2[c*5 +: 5] = 5'(logs[c]);
      chip_present[c] = pres[c];
      chip_ram[c] = rams[c];
    end
    for (int s = 0; s < 32; s++) begin m_map[s] = 0; m_ram[s] = 0; m_chip[s] = 0; m_page[s] = 0; end
    for (int s = 0; s < 8; s++) begin v_val[s] = 0; v_ram[s] = 0; v_chip[s] = 0; v_page[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    probe_cpu(16'h0000, 1'b0, "R9");
    probe_cpu(16'h8000, 1'b1, "R9");
    probe_vid(13'h0000, "R9");
    probe_vid(13'h1FFF, "R9");

    // R2 R3 R10: 32 KB window, bank masked to 128 KB chip
    command(0, 4, 16'h8123, 0, 7);
    probe_cpu(16'h8000, 1'b0, "R10");
    probe_cpu(16'hF7FF, 1'b0, "R2");
    probe_cpu(16'h9ABC, 1'b0, "R3");

    // R3: 8 KB window, base rounded down
    command(0, 2, 16'hD000, 0, 8'h25);
    probe_cpu(16'hC000, 1'b0, "R3");
    probe_cpu(16'hDFFF, 1'b0, "R3");

    // R4: 16 KB window on 8 KB chip wraps
    command(0, 3, 16'h4000, 1, 1);
    probe_cpu(16'h4000, 1'b0, "R4");
    probe_cpu(16'h6800, 1'b1, "R4");

    // R5: write gating
    probe_cpu(16'h6800, 1'b1, "R5");
    probe_cpu(16'h8000, 1'b1, "R5");
    probe_cpu(16'h0000, 1'b1, "R5");

    // R1: 2 KB window, 2 KB chip
    command(0, 0, 16'h2000, 2, 5);
    probe_cpu(16'h27FF, 1'b0, "R1");
    probe_cpu(16'h2345, 1'b1, "R1");

    // R6: absent chip unmaps its window only
    command(0, 2, 16'hC000, 3, 0);
    probe_cpu(16'hC000, 1'b1, "R6");
    probe_cpu(16'hDFFF, 1'b0, "R6");
    probe_cpu(16'hE000, 1'b0, "R6");

    // R2: size code 7 acts as 32 KB
    command(0, 7, 16'h0000, 0, 1);
    probe_cpu(16'h7800, 1'b0, "R2");
    probe_cpu(16'h0000, 1'b0, "R2");

    // R7: video windows
    command(1, 3, 13'h0000, 2, 1);
    probe_vid(13'h0C00, "R7");
    probe_vid(13'h1400, "R7");
    command(1, 2, 13'h1000, 0, 9);
    probe_vid(13'h1000, "R7");
    probe_vid(13'h1FFF, "R7");
    command(1, 0, 13'h0400, 1, 10);
    probe_vid(13'h07FF, "R7");

    // R8: absent chip on video table ignored
    command(1, 2, 13'h0000, 3, 0);
    probe_vid(13'h0400, "R8");
    probe_vid(13'h0000, "R8");
    probe_vid(13'h0C00, "R8");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard left %0d items", exp_q.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule